// File: doc/BRIEF.md
# OTP Adaptive Burn Sequencer

This block sits on the programmer side of a one-time-programmable memory that is accessed one byte at a time. The memory has no address pins: an internal address pointer is cleared by a dedicated mode and is advanced by pulses on a stepping clock. The block brings up the supplies, clears the pointer and then burns every byte from address zero to a parameterised last address. The supplies are modelled as two enable outputs.

For each byte, the sequencer requests the source data over a request/valid handshake. It then drives the data bus and issues fixed-width write pulses, releasing the bus and reading the byte back after each pulse. Once the read-back matches, it applies one over-programming pulse whose length is the attempt count times the base pulse width, limited by a ceiling. It then steps the device pointer with four clock pulses.

After the last byte, the sequencer returns the device to pointer-clear mode, lowers the programming supply and reports done. A byte that still mismatches after the allowed number of attempts stops the run. In that case the sequencer reports fail and holds the failing address and the byte that was read back. All delays come from one shared down-counter, scaled from a clock-frequency parameter.

Top module: `otp_burn_seq`

## Requirements
- R1: After reset, supply_on, prog_boost, dq_oe, step_clk, src_req, busy, done and fail are 0, and mode_pins is 4'b0000.
- R2: After start, supply_on rises and mode_pins stays 4'b0000 for PWR_US microseconds. Then pointer-clear mode is entered, and prog_boost rises only while supply_on is high.
- R3: mode_pins carries {MD3,MD2,MD1,MD0}. The encodings are: pointer-clear 4'b0101, write 4'b1110, read-back 4'b1100, inhibit 4'b1111 ahead of a write and 4'b1101 otherwise, and off 4'b0000.
- R4: Every normal write pulse keeps mode_pins at the write code for exactly WRITE_US microseconds and is followed by an inhibit code.
- R5: dq_out drives the source byte with dq_oe high for at least SETUP_US before each write pulse starts and HOLD_US after it ends. dq_oe is low for the whole read-back and for the cycle before it.
- R6: A read-back that differs from the source byte causes another write pulse. A byte that needs N pulses receives exactly N normal pulses.
- R7: After a matching read-back, exactly one further write pulse of min(N × WRITE_US, OVP_MAX_US) microseconds is applied.
- R8: After that pulse, exactly four step_clk pulses are issued with inhibit code 4'b1101 and dq_oe low. Each high and low phase lasts at least 1/8 µs.
- R9: src_req stays high with a stable src_addr until src_valid is seen. The byte is taken in the cycle where both are high. Addresses are requested in order from 0 to LAST_ADDR.
- R10: After the last address has been stepped, pointer-clear is entered and prog_boost drops. done is then raised, with supply_on low and mode_pins at 4'b0000.
- R11: If the read-back still mismatches after MAX_TRIES normal pulses, fail is raised and no further write pulse is issued. fail_addr holds the byte address and fail_data holds the last read-back value.
- R12: start has no effect while busy. A start after done or fail begins a new run at address 0, with done, fail, fail_addr and fail_data cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of CLK_KHZ kHz |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a burn run when idle, done or failed |
| src_req | output | 1 | Request for the source byte at src_addr |
| src_addr | output | ADDR_W | Byte address being burned |
| src_valid | input | 1 | Source byte present on src_data |
| src_data | input | 8 | Source byte |
| supply_on | output | 1 | Enable for nominal device and programming supplies |
| prog_boost | output | 1 | Enable for raised programming-level supplies |
| mode_pins | output | 4 | Device mode-select pins {MD3,MD2,MD1,MD0} |
| step_clk | output | 1 | Device address-stepping clock |
| dq_out | output | 8 | Data driven toward the device |
| dq_oe | output | 1 | Output enable for dq_out |
| dq_in | input | 8 | Data read from the device |
| busy | output | 1 | Run in progress |
| done | output | 1 | All bytes burned |
| fail | output | 1 | A byte exhausted its attempts |
| fail_addr | output | ADDR_W | Address of the failing byte |
| fail_data | output | 8 | Last value read back from the failing byte |

## Verification
The embedded properties rely on three assumptions about the inputs. First, the source raises src_valid only while src_req is high. Second, the device data lines are only sampled during read-back. Third, OVP_MAX_US is at least WRITE_US, so the pulse-width ceilings nest. The bench keeps to these assumptions: its source answers only an open request and drops valid the cycle after, and its device model changes dq_in only while the read-back code is present.

The model counts write pulses per address from the mode pins and reads back an inverted byte until a per-address pulse count is reached. This exercises single-pulse bytes, multi-pulse bytes, the over-programming ceiling and a byte that never verifies.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_PWRUP, S_CLR, S_RAISE, S_FETCH,
    S_WSETUP, S_WRITE, S_WHOLD, S_VSETUP, S_VERIFY, S_JUDGE,
    S_CKHI, S_CKLO, S_FIN, S_PDOWN, S_DONE, S_FAIL
  } seq_state_t;

  // mode pin codes, bit order {MD3,MD2,MD1,MD0}
  localparam logic [3:0] MODE_OFF    = 4'b0000;
  localparam logic [3:0] MODE_CLEAR  = 4'b0101;
  localparam logic [3:0] MODE_WRITE  = 4'b1110;
  localparam logic [3:0] MODE_VERIFY = 4'b1100;
  localparam logic [3:0] MODE_INH_W  = 4'b1111;
  localparam logic [3:0] MODE_INH_V  = 4'b1101;

endpackage

// File: rtl/otp_seq_timer.sv
module otp_seq_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                cnt_d = load_val;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // an expired count stays expired until reloaded (supports R4)
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);

endmodule

// File: rtl/otp_seq_tries.sv
module otp_seq_tries #(
  parameter int TW        = 16,
  parameter int TRY_W     = 5,
  parameter int MAX_TRIES = 20,
  parameter int WRITE_CYC = 1000,
  parameter int CAP_CYC   = 21000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic          at_max,
  output logic [TW-1:0] ovp_len
);

  localparam int PW = TW + TRY_W;

  logic [TRY_W-1:0] tries_q, tries_d;
  logic [PW-1:0]    prod;

  always_comb begin
    tries_d = tries_q;
    if (clr)      tries_d = '0;
    else if (inc) tries_d = tries_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tries_q <= '0;
    else        tries_q <= tries_d;
  end

  assign at_max  = (tries_q == TRY_W'(MAX_TRIES));
  assign prod    = PW'(tries_q) * PW'(WRITE_CYC);
  assign ovp_len = (prod > PW'(CAP_CYC)) ? TW'(CAP_CYC) : TW'(prod);

  p_tries_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= TRY_W'(MAX_TRIES));

  p_inc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (tries_q == $past(tries_q) + 1'b1));

endmodule

// File: rtl/otp_seq_ctrl.sv
module otp_seq_ctrl
  import otp_seq_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int LAST_ADDR = 24319,
  parameter int TW        = 16,
  parameter int PCW       = 2,
  parameter int STEPS     = 4,
  parameter int PWR_CYC   = 80,
  parameter int SET_CYC   = 16,
  parameter int HOLD_CYC  = 16,
  parameter int WRITE_CYC = 8000,
  parameter int CAP_CYC   = 168000,
  parameter int PCK_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              src_valid,
  input  logic [7:0]        src_data,
  input  logic [7:0]        dq_in,
  input  logic              tmr_zero,
  input  logic              at_max,
  input  logic [TW-1:0]     ovp_len,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  output logic              try_clr,
  output logic              try_inc,
  output logic              src_req,
  output logic [ADDR_W-1:0] src_addr,
  output logic              supply_on,
  output logic              prog_boost,
  output logic [3:0]        mode_pins,
  output logic              step_clk,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [7:0]        fail_data
);

  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        byte_q, byte_d;
  logic [7:0]        rd_q, rd_d;
  logic              match_q, match_d;
  logic              ovp_q, ovp_d;
  logic [PCW-1:0]    step_q, step_d;
  logic [ADDR_W-1:0] faddr_q, faddr_d;
  logic [7:0]        fdata_q, fdata_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    byte_d  = byte_q;
    rd_d    = rd_q;
    match_d = match_q;
    ovp_d   = ovp_q;
    step_d  = step_q;
    faddr_d = faddr_q;
    fdata_d = fdata_q;
    try_clr = 1'b0;
    try_inc = 1'b0;
    unique case (state_q)
      S_IDLE, S_DONE, S_FAIL: if (start) begin
        state_d = S_PWRUP;
        addr_d  = '0;
        faddr_d = '0;
        fdata_d = '0;
      end
      S_PWRUP:  if (tmr_zero) state_d = S_CLR;
      S_CLR:    if (tmr_zero) state_d = S_RAISE;
      S_RAISE:  if (tmr_zero) state_d = S_FETCH;
      S_FETCH:  if (src_valid) begin
        byte_d  = src_data;
        ovp_d   = 1'b0;
        try_clr = 1'b1;
        state_d = S_WSETUP;
      end
      S_WSETUP: if (tmr_zero) begin
        state_d = S_WRITE;
        try_inc = !ovp_q;
      end
      S_WRITE:  if (tmr_zero) state_d = S_WHOLD;
      S_WHOLD:  if (tmr_zero) begin
        step_d  = '0;
        state_d = ovp_q ? S_CKHI : S_VSETUP;
      end
      S_VSETUP: if (tmr_zero) state_d = S_VERIFY;
      S_VERIFY: if (tmr_zero) begin
        rd_d    = dq_in;
        match_d = (dq_in == byte_q);
        state_d = S_JUDGE;
      end
      S_JUDGE: begin
        if (match_q) begin
          ovp_d   = 1'b1;
          state_d = S_WSETUP;
        end else if (at_max) begin
          faddr_d = addr_q;
          fdata_d = rd_q;
          state_d = S_FAIL;
        end else begin
          state_d = S_WSETUP;
        end
      end
      S_CKHI:   if (tmr_zero) state_d = S_CKLO;
      S_CKLO:   if (tmr_zero) begin
        if (step_q == PCW'(STEPS - 1)) begin
          if (addr_q == ADDR_W'(LAST_ADDR)) state_d = S_FIN;
          else begin
            addr_d  = addr_q + 1'b1;
            state_d = S_FETCH;
          end
        end else begin
          step_d  = step_q + 1'b1;
          state_d = S_CKHI;
        end
      end
      S_FIN:    if (tmr_zero) state_d = S_PDOWN;
      S_PDOWN:  if (tmr_zero) state_d = S_DONE;
      default:  state_d = S_IDLE;
    endcase
  end

  // shared timer is loaded on every state change with the new state's span
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      S_PWRUP, S_PDOWN:                     tmr_val = TW'(PWR_CYC - 1);
      S_CLR, S_RAISE, S_FIN:                tmr_val = TW'(SET_CYC - 1);
      S_WSETUP, S_VSETUP, S_VERIFY:         tmr_val = TW'(SET_CYC - 1);
      S_WHOLD:                              tmr_val = TW'(HOLD_CYC - 1);
      S_WRITE:  tmr_val = ovp_q ? (ovp_len - 1'b1) : TW'(WRITE_CYC - 1);
      S_CKHI, S_CKLO:                       tmr_val = TW'(PCK_CYC - 1);
      default:                              tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      byte_q  <= '0;
      rd_q    <= '0;
      match_q <= 1'b0;
      ovp_q   <= 1'b0;
      step_q  <= '0;
      faddr_q <= '0;
      fdata_q <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      byte_q  <= byte_d;
      rd_q    <= rd_d;
      match_q <= match_d;
      ovp_q   <= ovp_d;
      step_q  <= step_d;
      faddr_q <= faddr_d;
      fdata_q <= fdata_d;
    end
  end

  // output decode
  always_comb begin
    unique case (state_q)
      S_CLR, S_RAISE, S_FIN, S_PDOWN:              mode_pins = MODE_CLEAR;
      S_WSETUP, S_WHOLD:                           mode_pins = MODE_INH_W;
      S_WRITE:                                     mode_pins = MODE_WRITE;
      S_VERIFY:                                    mode_pins = MODE_VERIFY;
      S_FETCH, S_VSETUP, S_JUDGE, S_CKHI, S_CKLO:  mode_pins = MODE_INH_V;
      default:                                     mode_pins = MODE_OFF;
    endcase
  end

  assign supply_on  = !(state_q inside {S_IDLE, S_DONE, S_FAIL});
  assign prog_boost = supply_on && !(state_q inside {S_PWRUP, S_CLR, S_PDOWN});
  assign dq_oe      = state_q inside {S_WSETUP, S_WRITE, S_WHOLD};
  assign dq_out     = byte_q;
  assign step_clk   = (state_q == S_CKHI);
  assign src_req    = (state_q == S_FETCH);
  assign src_addr   = addr_q;
  assign busy       = supply_on;
  assign done       = (state_q == S_DONE);
  assign fail       = (state_q == S_FAIL);
  assign fail_addr  = faddr_q;
  assign fail_data  = fdata_q;

  // ---------------- checker counters and properties ----------------
  logic [TW-1:0] su_cnt, wr_cnt, hold_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      su_cnt    <= '0;
      wr_cnt    <= '0;
      hold_left <= '0;
    end else begin
      if (dq_oe && mode_pins == MODE_INH_W) begin
        if (su_cnt != '1) su_cnt <= su_cnt + 1'b1;
      end else su_cnt <= '0;
      if (mode_pins == MODE_WRITE) wr_cnt <= wr_cnt + 1'b1;
      else                         wr_cnt <= '0;
      if (mode_pins == MODE_WRITE)  hold_left <= TW'(HOLD_CYC);
      else if (hold_left != '0)     hold_left <= hold_left - 1'b1;
    end
  end

  p_setup_before_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pins == MODE_WRITE && $past(mode_pins) != MODE_WRITE) |-> (su_cnt >= TW'(SET_CYC)));

  p_hold_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_left != '0 && mode_pins != MODE_WRITE) |-> (dq_oe && mode_pins == MODE_INH_W));

  p_released_for_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pins == MODE_VERIFY) |-> (!dq_oe && !$past(dq_oe)));

  p_write_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pins == MODE_WRITE && !ovp_q) |-> (wr_cnt < TW'(WRITE_CYC)));

  p_ovp_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pins == MODE_WRITE) |-> (wr_cnt < TW'(CAP_CYC)));

  p_step_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_clk |-> (mode_pins == MODE_INH_V && !dq_oe));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req && !src_valid) |=> (src_req && $stable(src_addr)));

  p_boost_needs_supply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_boost |-> supply_on);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!supply_on && mode_pins == MODE_OFF && !fail));

  p_fail_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!supply_on && !dq_oe && mode_pins == MODE_OFF));

endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq #(
  parameter int CLK_KHZ    = 8000,
  parameter int ADDR_W     = 15,
  parameter int LAST_ADDR  = 24319,
  parameter int MAX_TRIES  = 20,
  parameter int PWR_US     = 10,
  parameter int SETUP_US   = 2,
  parameter int HOLD_US    = 2,
  parameter int WRITE_US   = 1000,
  parameter int OVP_MAX_US = 21000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              src_req,
  output logic [ADDR_W-1:0] src_addr,
  input  logic              src_valid,
  input  logic [7:0]        src_data,
  output logic              supply_on,
  output logic              prog_boost,
  output logic [3:0]        mode_pins,
  output logic              step_clk,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  input  logic [7:0]        dq_in,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [7:0]        fail_data
);

  function automatic int us_to_cyc(input int us);
    int c;
    c = (us * CLK_KHZ + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int STEPS     = 4;
  localparam int PWR_CYC   = us_to_cyc(PWR_US);
  localparam int SET_CYC   = us_to_cyc(SETUP_US);
  localparam int HOLD_CYC  = us_to_cyc(HOLD_US);
  localparam int WRITE_CYC = us_to_cyc(WRITE_US);
  localparam int CAP_CYC   = us_to_cyc(OVP_MAX_US);
  localparam int PCK_CYC   = (CLK_KHZ + 7999) / 8000;
  localparam int MAX_A     = (CAP_CYC > WRITE_CYC) ? CAP_CYC : WRITE_CYC;
  localparam int MAX_CYC   = (MAX_A > PWR_CYC) ? MAX_A : PWR_CYC;
  localparam int TW        = $clog2(MAX_CYC + 1) + 1;
  localparam int TRY_W     = $clog2(MAX_TRIES + 1);
  localparam int PCW       = $clog2(STEPS);

  // asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  logic          tmr_load, tmr_zero, try_clr, try_inc, at_max;
  logic [TW-1:0] tmr_val, ovp_len;

  otp_seq_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  otp_seq_tries #(
    .TW(TW), .TRY_W(TRY_W), .MAX_TRIES(MAX_TRIES),
    .WRITE_CYC(WRITE_CYC), .CAP_CYC(CAP_CYC)
  ) u_tries (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .clr     (try_clr),
    .inc     (try_inc),
    .at_max  (at_max),
    .ovp_len (ovp_len)
  );

  otp_seq_ctrl #(
    .ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR), .TW(TW), .PCW(PCW), .STEPS(STEPS),
    .PWR_CYC(PWR_CYC), .SET_CYC(SET_CYC), .HOLD_CYC(HOLD_CYC),
    .WRITE_CYC(WRITE_CYC), .CAP_CYC(CAP_CYC), .PCK_CYC(PCK_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .start      (start),
    .src_valid  (src_valid),
    .src_data   (src_data),
    .dq_in      (dq_in),
    .tmr_zero   (tmr_zero),
    .at_max     (at_max),
    .ovp_len    (ovp_len),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .try_clr    (try_clr),
    .try_inc    (try_inc),
    .src_req    (src_req),
    .src_addr   (src_addr),
    .supply_on  (supply_on),
    .prog_boost (prog_boost),
    .mode_pins  (mode_pins),
    .step_clk   (step_clk),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .fail_addr  (fail_addr),
    .fail_data  (fail_data)
  );

endmodule

// File: tb/otp_burn_seq_bench.sv
module otp_burn_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int LAST_ADDR  = 3;
  localparam int WRITE_CYC  = 1000;   // 1000 us at 1 MHz
  localparam int CAP_CYC    = 2500;
  localparam int MAX_TRIES  = 20;

  logic              clk = 1'b0;
  logic              rst_n, start, src_valid;
  logic [7:0]        src_data, dq_in;
  logic              src_req, supply_on, prog_boost, step_clk, dq_oe, busy, done, fail;
  logic [ADDR_W-1:0] src_addr, fail_addr;
  logic [3:0]        mode_pins;
  logic [7:0]        dq_out, fail_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_burn_seq #(
    .CLK_KHZ(1000), .ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR), .MAX_TRIES(MAX_TRIES),
    .PWR_US(10), .SETUP_US(2), .HOLD_US(2), .WRITE_US(1000), .OVP_MAX_US(2500)
  ) u_otp_burn_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_req(src_req), .src_addr(src_addr), .src_valid(src_valid), .src_data(src_data),
    .supply_on(supply_on), .prog_boost(prog_boost), .mode_pins(mode_pins),
    .step_clk(step_clk), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr), .fail_data(fail_data)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // device and source model state
  logic [7:0] pat [0:15];
  logic [7:0] mem [0:15];
  int  need [0:15];
  int  wcnt [0:15];
  int  ovpw [0:15];
  bit  passed [0:15];
  int  dev_addr, sub, steps, clears, oe_viol, data_viol, width_viol, pw_cyc;
  int  fetch_next, order_viol, fetches, wlen;
  bit  was_ovp;
  logic [3:0] md_q;
  logic       sc_q;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'hFF; wcnt[i] = 0; ovpw[i] = 0; passed[i] = 0;
    end
    dev_addr = 0; sub = 0; steps = 0; clears = 0; oe_viol = 0; data_viol = 0;
    width_viol = 0; pw_cyc = 0; fetch_next = 0; order_viol = 0; fetches = 0;
  endtask

  // device model and monitor, sampled away from the active edge
  initial begin
    dq_in = 8'h00; md_q = 4'b0000; sc_q = 1'b0; wlen = 0; was_ovp = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (supply_on && mode_pins == 4'b0000) pw_cyc++;
        if (mode_pins == 4'b0101 && md_q != 4'b0101) begin
          clears++; dev_addr = 0; sub = 0;
        end
        if (step_clk && !sc_q) begin
          steps++; sub++;
          if (sub == 4) begin sub = 0; dev_addr = (dev_addr + 1) & 15; end
        end
        if (mode_pins == 4'b1110) begin
          if (md_q != 4'b1110) begin
            wlen = 0;
            was_ovp = passed[dev_addr];
            if (!dq_oe || dq_out != pat[dev_addr]) data_viol++;
            mem[dev_addr] = dq_out;
            if (!was_ovp) wcnt[dev_addr]++;
          end
          wlen++;
        end else if (md_q == 4'b1110) begin
          if (was_ovp) ovpw[dev_addr] = wlen;
          else if (wlen != WRITE_CYC) width_viol++;
        end
        if (mode_pins == 4'b1100) begin
          if (dq_oe) oe_viol++;
          if (md_q != 4'b1100) begin
            if (wcnt[dev_addr] >= need[dev_addr]) begin
              dq_in = mem[dev_addr]; passed[dev_addr] = 1;
            end else dq_in = ~mem[dev_addr];
          end
        end
        md_q = mode_pins; sc_q = step_clk;
      end
    end
  end

  // source responder
  initial begin
    int waitc;
    src_valid = 1'b0; src_data = 8'h00; waitc = 0;
    forever begin
      @(negedge clk);
      if (src_valid) begin
        src_valid = 1'b0; waitc = 0;
      end else if (src_req) begin
        if (waitc >= int'(src_addr) % 3) begin
          if (int'(src_addr) != fetch_next) order_viol++;
          fetch_next++; fetches++;
          src_data = pat[src_addr]; src_valid = 1'b1;
        end else waitc++;
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end(input int limit);
    int n = 0;
    while (!done && !fail && n < limit) begin
      @(negedge clk); n++;
    end
    chk(n < limit, "R10 run ends in time", n, limit);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!supply_on && !prog_boost, "R1 supplies off", {supply_on, prog_boost}, 0);
    chk(mode_pins == 4'b0000, "R1 mode off", mode_pins, 0);
    chk(!dq_oe && !step_clk && !src_req, "R1 bus idle", {dq_oe, step_clk, src_req}, 0);
    chk(!busy && !done && !fail, "R1 status clear", {busy, done, fail}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && mode_pins == 4'b0000, "R1 idle after release", mode_pins, 0);
  endtask

  task automatic t_burn();
    int exp_ovp;
    pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'hF0; pat[3] = 8'h0F;
    need[0] = 1; need[1] = 3; need[2] = 1; need[3] = 2;
    model_reset();
    pulse_start();
    repeat (3000) @(negedge clk);
    pulse_start();                         // R12: ignored while busy
    wait_end(60000);
    chk(pw_cyc == 10, "R2 power-up wait", pw_cyc, 10);
    chk(clears == 2, "R3 R12 clear-mode entries", clears, 2);
    chk(width_viol == 0, "R4 write pulse width", width_viol, 0);
    chk(data_viol == 0, "R5 data driven at write", data_viol, 0);
    chk(oe_viol == 0, "R5 bus released in read-back", oe_viol, 0);
    for (int a = 0; a <= LAST_ADDR; a++) begin
      exp_ovp = (need[a] * WRITE_CYC > CAP_CYC) ? CAP_CYC : need[a] * WRITE_CYC;
      chk(wcnt[a] == need[a], "R6 normal pulses per byte", wcnt[a], need[a]);
      chk(ovpw[a] == exp_ovp, "R7 extra pulse length", ovpw[a], exp_ovp);
      chk(mem[a] == pat[a], "R9 byte burned", mem[a], pat[a]);
    end
    chk(steps == 16, "R8 step pulses", steps, 16);
    chk(order_viol == 0 && fetches == 4, "R9 fetch order", fetches, 4);
    chk(done && !fail, "R10 done raised", {done, fail}, 2);
    chk(!supply_on && !prog_boost && mode_pins == 4'b0000, "R10 quiet at end",
        {supply_on, prog_boost, mode_pins}, 0);
  endtask

  task automatic t_fail();
    pat[0] = 8'h11; pat[1] = 8'h22; pat[2] = 8'h33; pat[3] = 8'h44;
    need[0] = 1; need[1] = 99; need[2] = 1; need[3] = 1;
    model_reset();
    pulse_start();
    chk(!done, "R12 done cleared on restart", done, 0);
    wait_end(60000);
    chk(fail && !done, "R11 fail raised", {fail, done}, 2);
    chk(fail_addr == 4'd1, "R11 failing address", fail_addr, 1);
    chk(fail_data == 8'hDD, "R11 read-back byte", fail_data, 8'hDD);
    chk(wcnt[1] == MAX_TRIES, "R11 attempts before giving up", wcnt[1], MAX_TRIES);
    chk(ovpw[1] == 0, "R11 no extra pulse on failing byte", ovpw[1], 0);
    repeat (200) @(negedge clk);
    chk(wcnt[2] == 0 && mode_pins == 4'b0000, "R11 no writes after fail", wcnt[2], 0);
  endtask

  task automatic t_restart();
    pat[0] = 8'h5A; pat[1] = 8'hC3; pat[2] = 8'h81; pat[3] = 8'h7E;
    for (int i = 0; i < 16; i++) need[i] = 1;
    model_reset();
    pulse_start();
    chk(!fail && fail_addr == '0 && fail_data == 8'h00, "R12 fail state cleared",
        {fail, fail_addr, fail_data}, 0);
    wait_end(60000);
    chk(done && !fail, "R12 rerun completes", {done, fail}, 2);
    chk(fetches == 4 && order_viol == 0, "R12 rerun from address 0", fetches, 4);
    for (int a = 0; a <= LAST_ADDR; a++)
      chk(mem[a] == pat[a] && ovpw[a] == WRITE_CYC, "R7 single-try extra pulse", ovpw[a], WRITE_CYC);
  endtask

  initial begin
    t_reset();
    t_burn();
    t_fail();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule